// File: doc/BRIEF.md
# Six-Pin Parallel I/O Port

This block is a small memory-mapped general-purpose port of six pins, numbered 5 down to 0. Software reaches it through a synchronous register bus (address, write enable, write data, read data) and sees two byte-wide registers: a latch register that holds the levels to drive, and a direction register that turns each pin's output driver on or off. The pad side gets one output value and one output enable per pin, and returns one input level per pin.

Reading the latch register gives, bit by bit, either the latched value (pins that are driving) or the resynchronized pin level (pins that are listening). Two pins are fixed in function. Pin 5 can only listen: its direction bit is not stored and always reads zero. Pin 4 can only drive: its direction bit is stored and reads back, but the pin drives in every cycle outside reset whatever the bit holds. Input levels cross into the clock domain through a two-flop synchronizer before reaching the read path.

Top module: `pario_port`

## Requirements
- R1: While reset is high, every output enable is zero. After reset, the latch register and the direction register both read as zero and every pin output value is zero.
- R2: For pins 0 to 3, a direction bit of 1 sets that pin's output enable and a direction bit of 0 clears it.
- R3: A write to the latch register (address 0) stores bits 5..0 of the write data into all six bits, including bits of pins that are currently inputs; the pin output value equals the stored bit for every pin.
- R4: Reading address 0 returns, for each bit, the stored latch bit if the pin is driving and the synchronized pin level if it is not.
- R5: Pin 5 is input-only: its output enable is never set, bit 5 of the direction register (address 1) always reads 0, and bit 5 of address 0 always returns the synchronized pin level.
- R6: Pin 4 is output-only: its output enable is 1 in every cycle when reset is low, regardless of direction bit 4; bit 4 of address 0 returns the stored latch bit; direction bit 4 reads back the value written.
- R7: A pin level change appears on the read data after the second rising clock edge that samples it, and not after the first.
- R8: A register write takes effect at the rising edge where the write enable is sampled high, not earlier; read data follows the address combinationally.
- R9: Bits 7 and 6 of both registers read as zero, whatever was written to them.
- R10: Writes to addresses 2 and 3 change neither register, and reads of addresses 2 and 3 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select: 0 latch, 1 direction, 2 and 3 undefined |
| bus_we | input | 1 | Write enable, sampled at the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for the selected address |
| pin_in | input | 6 | Pin levels from the pads |
| pin_out | output | 6 | Level to drive on each pin |
| pin_oe | output | 6 | Output driver enable per pin |

## Verification
The bench builds the block with its default parameters: six pins, a byte-wide bus, a two-bit address, pin 5 listening only and pin 4 driving only, and two synchronizer stages. With six direction bits the whole direction space is only 64 values, so every one of them is paired with several latch patterns and opposite pin levels, which exposes any bit whose read source or enable is taken from the wrong place. The small synchronizer depth lets the bench probe the exact edge at which a pin change becomes visible.

// File: rtl/pario_pkg.sv
package pario_pkg;

    // Fixed role a pin can have in the port
    typedef enum logic [1:0] {
        PIN_BIDIR    = 2'd0,
        PIN_IN_ONLY  = 2'd1,
        PIN_OUT_ONLY = 2'd2
    } pin_kind_e;

    // Decoded register access for one bus cycle
    typedef struct packed {
        logic hit_latch;
        logic hit_dir;
    } reg_hit_t;

    function automatic pin_kind_e kind_of(input int idx, input int in_only, input int out_only);
        if (idx == in_only)  return PIN_IN_ONLY;
        if (idx == out_only) return PIN_OUT_ONLY;
        return PIN_BIDIR;
    endfunction

    // Mask of direction bits that have storage
    function automatic logic [31:0] dir_keep_mask(input int npins, input int in_only);
        logic [31:0] m;
        m = '0;
        for (int i = 0; i < npins; i++) begin
            m[i] = (i != in_only);
        end
        return m;
    endfunction

endpackage

// File: rtl/pario_sync.sv
module pario_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pario_regs.sv
module pario_regs
    import pario_pkg::*;
#(
    parameter int              NPINS      = 6,
    parameter int              ADDR_W     = 2,
    parameter int              LATCH_ADDR = 0,
    parameter int              DIR_ADDR   = 1,
    parameter logic [NPINS-1:0] DIR_KEEP  = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [NPINS-1:0]  wdata,
    output logic [NPINS-1:0]  latch_q,
    output logic [NPINS-1:0]  dir_q
);
    reg_hit_t hit;

    always_comb begin
        hit.hit_latch = we && (addr == ADDR_W'(LATCH_ADDR));
        hit.hit_dir   = we && (addr == ADDR_W'(DIR_ADDR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            latch_q <= '0;
            dir_q   <= '0;
        end else begin
            if (hit.hit_latch) latch_q <= wdata;
            if (hit.hit_dir)   dir_q   <= wdata & DIR_KEEP;
        end
    end
endmodule

// File: rtl/pario_pinctl.sv
module pario_pinctl
    import pario_pkg::*;
#(
    parameter int NPINS        = 6,
    parameter int IN_ONLY_PIN  = 5,
    parameter int OUT_ONLY_PIN = 4
) (
    input  logic             rst,
    input  logic [NPINS-1:0] latch_q,
    input  logic [NPINS-1:0] dir_q,
    input  logic [NPINS-1:0] sync_in,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] rd_latch,
    output logic [NPINS-1:0] rd_dir
);
    logic [NPINS-1:0] drive;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        localparam pin_kind_e KIND = kind_of(i, IN_ONLY_PIN, OUT_ONLY_PIN);
        if (KIND == PIN_IN_ONLY) begin : g_in
            assign drive[i] = 1'b0;
        end else if (KIND == PIN_OUT_ONLY) begin : g_out
            assign drive[i] = 1'b1;
        end else begin : g_bi
            assign drive[i] = dir_q[i];
        end
        assign rd_dir[i]   = dir_q[i];
        assign pin_oe[i]   = drive[i] & ~rst;
        assign rd_latch[i] = drive[i] ? latch_q[i] : sync_in[i];
    end

    assign pin_out = latch_q;
endmodule

// File: rtl/pario_port.sv
module pario_port
    import pario_pkg::*;
#(
    parameter int NPINS        = 6,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 2,
    parameter int LATCH_ADDR   = 0,
    parameter int DIR_ADDR     = 1,
    parameter int IN_ONLY_PIN  = 5,
    parameter int OUT_ONLY_PIN = 4,
    parameter int SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe
);
    localparam int              PAD_W    = DATA_W - NPINS;
    localparam logic [31:0]     KEEP32   = dir_keep_mask(NPINS, IN_ONLY_PIN);
    localparam logic [NPINS-1:0] DIR_KEEP = KEEP32[NPINS-1:0];

    logic [NPINS-1:0] latch_q, dir_q, sync_in, rd_latch, rd_dir;
    logic             unused_hi;

    assign unused_hi = ^bus_wdata[DATA_W-1:NPINS];

    pario_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (sync_in)
    );

    pario_regs #(
        .NPINS(NPINS), .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR),
        .DIR_ADDR(DIR_ADDR), .DIR_KEEP(DIR_KEEP)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata[NPINS-1:0]),
        .latch_q (latch_q),
        .dir_q   (dir_q)
    );

    pario_pinctl #(
        .NPINS(NPINS), .IN_ONLY_PIN(IN_ONLY_PIN), .OUT_ONLY_PIN(OUT_ONLY_PIN)
    ) u_pinctl (
        .rst      (rst),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .sync_in  (sync_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .rd_latch (rd_latch),
        .rd_dir   (rd_dir)
    );

    always_comb begin
        if (bus_addr == ADDR_W'(LATCH_ADDR))
            bus_rdata = {{PAD_W{1'b0}}, rd_latch};
        else if (bus_addr == ADDR_W'(DIR_ADDR))
            bus_rdata = {{PAD_W{1'b0}}, rd_dir};
        else
            bus_rdata = '0;
    end
endmodule

// File: rtl/pario_port_chk.sv
module pario_port_chk #(
    parameter int NPINS        = 6,
    parameter int DATA_W       = 8,
    parameter int ADDR_W       = 2,
    parameter int LATCH_ADDR   = 0,
    parameter int DIR_ADDR     = 1,
    parameter int IN_ONLY_PIN  = 5,
    parameter int OUT_ONLY_PIN = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_out,
    input logic [NPINS-1:0]  pin_oe
);
    logic [1:0] age_q;
    logic       is_latch, is_dir, is_undef;

    always_ff @(posedge clk) begin
        if (rst)                age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign is_latch = (bus_addr == ADDR_W'(LATCH_ADDR));
    assign is_dir   = (bus_addr == ADDR_W'(DIR_ADDR));
    assign is_undef = !is_latch && !is_dir;

    a_r1_reset_quiet: assert property (@(posedge clk) rst |-> (pin_oe == '0));

    a_r5_never_drive: assert property (@(posedge clk) !pin_oe[IN_ONLY_PIN]);

    a_r6_always_drive: assert property (@(posedge clk) disable iff (rst)
        pin_oe[OUT_ONLY_PIN]);

    a_r3_latch_out: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_latch) |=> (pin_out == $past(bus_wdata[NPINS-1:0])));

    a_r8_dir_takes: assert property (@(posedge clk) disable iff (rst)
        (bus_we && is_dir) |=> (pin_oe[0] == $past(bus_wdata[0])));

    a_r9_hi_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[DATA_W-1:NPINS] == '0);

    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        is_undef |-> (bus_rdata == '0));

    a_r7_sync_depth: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2 && is_latch) |->
            (bus_rdata[IN_ONLY_PIN] == $past(pin_in[IN_ONLY_PIN], 2)));
endmodule

bind pario_port pario_port_chk #(
    .NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LATCH_ADDR(LATCH_ADDR),
    .DIR_ADDR(DIR_ADDR), .IN_ONLY_PIN(IN_ONLY_PIN), .OUT_ONLY_PIN(OUT_ONLY_PIN)
) u_chk (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/pario_port_test.sv
module pario_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [5:0] pin_in = 6'h00;
    logic [5:0] pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pario_port uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] v);
        bus_addr = a; bus_wdata = v; bus_we = 1'b1;
        edges(1);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [5:0] eff, exp_rd;
        logic [5:0] pats [4];
        pats[0] = 6'h00; pats[1] = 6'h3F; pats[2] = 6'h15; pats[3] = 6'h2A;

        // R1: reset state
        @(negedge clk);
        pin_in = 6'h3F;
        edges(2);
        chk("R1 oe in reset", {2'b0, pin_oe}, 8'h00);
        pin_in = 6'h00;
        edges(2);
        rst = 1'b0;
        edges(1);
        rd(2'd1, v); chk("R1 dir after reset", v, 8'h00);
        rd(2'd0, v); chk("R1 latch after reset", v, 8'h00);
        chk("R1 pin_out after reset", {2'b0, pin_out}, 8'h00);
        chk("R6 oe out-only after reset", {2'b0, pin_oe}, 8'h10);

        // R7: synchronizer depth with all pins listening
        pin_in = 6'h3F;
        bus_addr = 2'd0;
        edges(1);
        rd(2'd0, v); chk("R7 not after first edge", v, 8'h00);
        edges(1);
        rd(2'd0, v); chk("R7 after second edge", v, 8'h2F);

        // R8: write not seen before its edge; read is combinational
        bus_addr = 2'd1; bus_wdata = 8'h0F; bus_we = 1'b1;
        #1;
        chk("R8 oe before edge", {2'b0, pin_oe}, 8'h10);
        rd(2'd1, v); chk("R8 dir before edge", v, 8'h00);
        edges(1);
        bus_we = 1'b0;
        chk("R8 oe after edge", {2'b0, pin_oe}, 8'h1F);
        rd(2'd1, v); chk("R8 dir read comb", v, 8'h0F);
        rd(2'd0, v); chk("R8 latch read comb", v, 8'h20);

        // R10: undefined addresses
        wr(2'd2, 8'hFF);
        wr(2'd3, 8'hFF);
        rd(2'd1, v); chk("R10 dir untouched", v, 8'h0F);
        chk("R10 latch untouched", {2'b0, pin_out}, 8'h00);
        rd(2'd2, v); chk("R10 read addr2", v, 8'h00);
        rd(2'd3, v); chk("R10 read addr3", v, 8'h00);

        // R9: high bits written as ones read zero
        wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R9 R5 dir high bits", v, 8'h1F);

        // R3: latch while every pin is an input
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h2A);
        chk("R3 latch into inputs", {2'b0, pin_out}, 8'h2A);

        // Sweep every direction value against several latch patterns
        for (int d = 0; d < 64; d++) begin
            wr(2'd1, 8'(d) | 8'hC0);
            eff = (6'(d) & 6'h0F) | 6'h10;
            for (int p = 0; p < 4; p++) begin
                wr(2'd0, {2'b11, pats[p]});
                pin_in = ~pats[p];
                edges(2);
                chk("R2 R5 R6 oe", {2'b0, pin_oe}, {2'b0, eff});
                chk("R3 pin_out", {2'b0, pin_out}, {2'b0, pats[p]});
                exp_rd = (eff & pats[p]) | (~eff & ~pats[p]);
                rd(2'd0, v); chk("R4 R9 latch read", v, {2'b0, exp_rd});
                rd(2'd1, v); chk("R5 R6 dir read", v, {2'b0, 6'(d) & 6'h1F});
            end
        end

        // R1: reset in mid-run clears everything
        rst = 1'b1;
        #1;
        chk("R1 oe during late reset", {2'b0, pin_oe}, 8'h00);
        pin_in = 6'h00;
        edges(3);
        rst = 1'b0;
        #1;
        rd(2'd1, v); chk("R1 dir cleared", v, 8'h00);
        chk("R1 pin_out cleared", {2'b0, pin_out}, 8'h00);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule